// File: doc/BRIEF.md
# Next-PC sequencing unit

This block owns the program counter of a single-cycle 32-bit RISC core. On every rising clock edge it loads a new address. That address is one of three values. The first is the sequential address, which is the current address plus 4. The second is a PC-relative branch target. The third is a pseudo-direct jump target.

The choice depends on the opcode of the instruction word that is currently fetched and on the ALU zero flag computed for that instruction. Both the instruction word and the zero flag are inputs during the same cycle. The block also drives the sequential value as an output, so the core can use it as a link value.

Two conditional branches are recognised. One is taken when the zero flag is set and the other is taken when the zero flag is clear. One unconditional jump is recognised. Every other opcode steps to the next word. Synchronous reset has priority over everything else.

Top module: `npc_sequencer`

## Requirements
- R1: When `rst` is 1 at a rising edge, `pc` becomes 0 after that edge. This holds whatever instruction or zero flag is presented at the same time.
- R2: `pc_plus4` always equals `pc` + 4, computed modulo 2^32.
- R3: An opcode (instruction bits 31:26) other than 2, 4 or 5 loads `pc` + 4 at the next edge. The value of `alu_zero` makes no difference to this.
- R4: Opcode 4 (branch on equal) with `alu_zero` = 1 loads `pc` + 4 + (sign-extended bits 15:0 shifted left by 2).
- R5: Opcode 4 with `alu_zero` = 0 falls through to `pc` + 4.
- R6: Opcode 5 (branch on not-equal) with `alu_zero` = 0 loads the same branch target as R4. With `alu_zero` = 1 it falls through to `pc` + 4.
- R7: A negative 16-bit displacement branches backward. For example, an immediate of -3 gives `pc` + 4 - 12, and an immediate of -1 holds `pc` unchanged.
- R8: Opcode 2 (jump) loads {(`pc`+4)[31:28], instruction bits 25:0, 2'b00}. The value of `alu_zero` makes no difference to this.
- R9: The 4 region bits of a jump come from `pc` + 4, not from `pc`. At `pc` = 0xFFFFFFFC the region is 0. At `pc` = 0x0FFFFFFC the region is 1.
- R10: Sequential stepping wraps: from `pc` = 0xFFFFFFFC the next value is 0. A backward branch from 0 wraps down, so an immediate of -3 gives 0xFFFFFFF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word fetched at the current `pc` |
| alu_zero | input | 1 | ALU zero flag for the current instruction |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential address `pc` + 4 |

## Verification
Reset and a redirect can occur in the same cycle. The bench provokes this by asserting `rst` while a taken jump or a taken branch is presented. It then checks that `pc` reads 0 after the edge and not the redirect target. A second collision is a jump issued from the last word of a 256 MB region. At that point `pc` and `pc` + 4 lie in different regions, and the bench checks that the region bits follow `pc` + 4. A reference model in the bench uses 64-bit integer arithmetic. The bench compares `pc` and `pc_plus4` against this model after every edge.

// File: rtl/npc_pkg.sv
package npc_pkg;
  parameter int XLEN     = 32;
  parameter int OPC_W    = 6;
  parameter int IMM_W    = 16;
  parameter int JFIELD_W = 26;
  parameter int ALIGN    = 2;
  localparam int OPC_LSB  = XLEN - OPC_W;
  localparam int REGION_W = XLEN - JFIELD_W - ALIGN;

  typedef logic [XLEN-1:0] addr_t;
  typedef enum logic [1:0] {NPC_SEQ = 2'd0, NPC_BRANCH = 2'd1, NPC_JUMP = 2'd2} npc_sel_e;

  // Sequential step: one aligned word.
  function automatic addr_t seq_addr(addr_t cur);
    return cur + addr_t'(1 << ALIGN);
  endfunction

  // PC-relative target: link plus sign-extended, word-scaled displacement.
  function automatic addr_t branch_addr(addr_t link, logic [IMM_W-1:0] imm);
    addr_t ext;
    ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    return link + (ext << ALIGN);
  endfunction

  // Pseudo-direct target: region bits of link, field, alignment zeros.
  function automatic addr_t jump_addr(addr_t link, logic [JFIELD_W-1:0] field);
    return {link[XLEN-1 -: REGION_W], field, {ALIGN{1'b0}}};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter logic [OPC_W-1:0] BEQ_OPC = 6'd4,
  parameter logic [OPC_W-1:0] BNE_OPC = 6'd5,
  parameter logic [OPC_W-1:0] JMP_OPC = 6'd2
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero,
  output logic             is_beq,
  output logic             is_bne,
  output logic             is_jmp,
  output logic             br_taken,
  output npc_sel_e         sel
);
  always_comb begin
    is_beq   = (opcode == BEQ_OPC);
    is_bne   = (opcode == BNE_OPC);
    is_jmp   = (opcode == JMP_OPC);
    br_taken = (is_beq && zero) || (is_bne && !zero);
    if (is_jmp)        sel = NPC_JUMP;
    else if (br_taken) sel = NPC_BRANCH;
    else               sel = NPC_SEQ;
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  addr_t                cur_pc,
  input  logic [IMM_W-1:0]     imm,
  input  logic [JFIELD_W-1:0]  jfield,
  output addr_t                tgt_seq,
  output addr_t                tgt_br,
  output addr_t                tgt_jmp
);
  always_comb begin
    tgt_seq = seq_addr(cur_pc);
    tgt_br  = branch_addr(tgt_seq, imm);
    tgt_jmp = jump_addr(tgt_seq, jfield);
  end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
  import npc_pkg::*;
#(
  parameter logic [OPC_W-1:0] BEQ_OPC = 6'd4,
  parameter logic [OPC_W-1:0] BNE_OPC = 6'd5,
  parameter logic [OPC_W-1:0] JMP_OPC = 6'd2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [npc_pkg::XLEN-1:0]   instr,
  input  logic                       alu_zero,
  output logic [npc_pkg::XLEN-1:0]   pc,
  output logic [npc_pkg::XLEN-1:0]   pc_plus4
);
  logic [OPC_W-1:0]    opcode_w;
  logic [IMM_W-1:0]    imm_w;
  logic [JFIELD_W-1:0] jfield_w;
  logic                is_beq_w, is_bne_w, is_jmp_w, br_taken_w;
  npc_sel_e            sel_w;
  addr_t               tgt_seq_w, tgt_br_w, tgt_jmp_w, pc_next_w;

  assign opcode_w = instr[XLEN-1 -: OPC_W];
  assign imm_w    = instr[IMM_W-1:0];
  assign jfield_w = instr[JFIELD_W-1:0];

  npc_decode #(.BEQ_OPC(BEQ_OPC), .BNE_OPC(BNE_OPC), .JMP_OPC(JMP_OPC)) u_dec (
    .opcode(opcode_w), .zero(alu_zero), .is_beq(is_beq_w), .is_bne(is_bne_w),
    .is_jmp(is_jmp_w), .br_taken(br_taken_w), .sel(sel_w)
  );

  npc_targets u_tgt (
    .cur_pc(pc), .imm(imm_w), .jfield(jfield_w),
    .tgt_seq(tgt_seq_w), .tgt_br(tgt_br_w), .tgt_jmp(tgt_jmp_w)
  );

  always_comb begin
    unique case (sel_w)
      NPC_BRANCH: pc_next_w = tgt_br_w;
      NPC_JUMP:   pc_next_w = tgt_jmp_w;
      default:    pc_next_w = tgt_seq_w;
    endcase
  end

  npc_pc_reg #(.W(XLEN), .RESET_VAL('0)) u_pc (
    .clk(clk), .rst(rst), .d(pc_next_w), .q(pc)
  );

  assign pc_plus4 = tgt_seq_w;
endmodule

// File: rtl/npc_sequencer_chk.sv
module npc_sequencer_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic        alu_zero,
  input logic [31:0] pc,
  input logic [31:0] pc_plus4,
  input logic        br_taken
);
  logic [5:0]  op;
  logic [31:0] disp;
  assign op   = instr[31:26];
  assign disp = {{14{instr[15]}}, instr[15:0], 2'b00};

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> pc == 32'd0);  // R1
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
    pc_plus4 == pc + 32'd4);  // R2
  AST_FALL_OTHER: assert property (@(posedge clk) disable iff (rst)
    (op != 6'd2 && op != 6'd4 && op != 6'd5) |=> pc == $past(pc) + 32'd4);  // R3
  AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && alu_zero) |=> pc == $past(pc) + 32'd4 + $past(disp));  // R4
  AST_BEQ_NOT: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && !alu_zero) |=> pc == $past(pc) + 32'd4);  // R5
  AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd5 && !alu_zero) |=> pc == $past(pc) + 32'd4 + $past(disp));  // R6
  AST_BNE_NOT: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd5 && alu_zero) |=> pc == $past(pc) + 32'd4);  // R6
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> pc == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00});  // R8
  AST_TAKEN_OPC: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (op == 6'd4 || op == 6'd5));  // R3
endmodule

bind npc_sequencer npc_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .alu_zero(alu_zero),
  .pc(pc), .pc_plus4(pc_plus4), .br_taken(br_taken_w)
);

// File: tb/tb_npc_sequencer.sv
module tb_npc_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0;
  logic        zero = 1'b0;
  logic [31:0] pc, pc_plus4;
  logic [31:0] mdl_pc = 32'd0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  npc_sequencer dut (
    .clk(clk), .rst(rst), .instr(instr), .alu_zero(zero),
    .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic logic [31:0] model_next(logic [31:0] cur, logic [31:0] ins, logic z);
    longint link, res;
    int op, disp;
    link = (longint'(cur) + 4) % 64'h1_0000_0000;
    op   = int'(ins >> 26);
    disp = int'($signed(ins[15:0])) * 4;
    if (op == 2)
      res = (link / 268435456) * 268435456 + longint'(ins[25:0]) * 4;
    else if ((op == 4 && z) || (op == 5 && !z))
      res = link + disp;
    else
      res = link;
    return res[31:0];
  endfunction

  function automatic logic [31:0] enc_br(int op, int imm);
    logic [15:0] i16;
    i16 = imm[15:0];
    return {op[5:0], 10'd0, i16};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] f);
    return {6'd2, f};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic [31:0] ins, logic z, string tag);
    @(negedge clk);
    rst = r; instr = ins; zero = z;
    @(posedge clk);
    mdl_pc = r ? 32'd0 : model_next(mdl_pc, ins, z);
    #1;
    check(tag, pc, mdl_pc);
    check("R2", pc_plus4, mdl_pc + 32'd4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    cyc(1, 32'd0, 0, "R1");
    cyc(1, 32'd0, 1, "R1");
    cyc(0, enc_br(0, 5), 1, "R3");     // -> 4
    cyc(0, enc_br(35, 8), 0, "R3");    // -> 8
    cyc(0, enc_br(3, 9), 1, "R3");
    cyc(0, enc_br(6, 9), 0, "R3");     // -> 16
    cyc(0, enc_br(4, 5), 1, "R4");     // -> 40
    cyc(0, enc_br(4, 5), 0, "R5");     // -> 44
    cyc(0, enc_br(5, 2), 0, "R6");     // -> 56
    cyc(0, enc_br(5, 2), 1, "R6");     // -> 60
    cyc(0, enc_br(4, -3), 1, "R7");    // -> 52
    cyc(0, enc_br(5, -1), 0, "R7");    // hold at 52
    cyc(0, enc_j(26'h0000100), 0, "R8");
    cyc(0, enc_j(26'h0000040), 1, "R8");
    cyc(1, enc_j(26'h0000100), 0, "R1");  // reset beats jump
    cyc(0, enc_br(4, 7), 1, "R4");
    cyc(1, enc_br(4, 7), 1, "R1");        // reset beats taken branch
    cyc(0, enc_br(4, -3), 1, "R10");   // 0 -> FFFFFFF8
    cyc(0, enc_br(0, 0), 0, "R10");    // -> FFFFFFFC
    cyc(0, enc_br(0, 0), 0, "R10");    // wrap -> 0
    cyc(0, enc_br(4, -3), 1, "R7");
    cyc(0, enc_br(0, 0), 1, "R3");     // FFFFFFFC
    cyc(0, enc_j(26'h3FFFFFF), 0, "R9"); // -> 0FFFFFFC
    cyc(0, enc_j(26'h0000005), 1, "R9"); // -> 10000014
    cyc(0, enc_br(5, 100), 0, "R6");
    cyc(0, enc_br(4, -32768), 1, "R7");
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule